// File: doc/BRIEF.md
# Asynchronous Serial Word Receiver with Line-Error Flags

This block turns an asynchronous serial input into parallel words. The frame format is set by static configuration inputs. Each word has 5 to 8 data bits, an optional parity bit, and one or two stop bits. The line is sampled on an oversampling tick that comes from an external baud generator, with `OSR` ticks per bit and 16 ticks by default. The serial input can be inverted before any decoding. It then passes through a two-flop synchroniser.

Each accepted frame produces a one-cycle `word_valid` pulse. The pulse carries the right-aligned data word and three per-word indications: parity error, framing error and break character. Three sticky flags record parity errors, framing errors and breaks on the line. Software clears each flag by pulsing its clear strobe. A line-status output is high while any of the three flags is set.

Top module: `srx_receiver`

## Requirements
- R1: `cfg_wlen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives least significant bit first. `word_data` holds the word right-aligned, with unused upper bits at 0.
- R2: A falling edge starts a frame only if the line is still low at tick 8 of the start bit. A low pulse of fewer than 8 ticks produces no word.
- R3: With `cfg_par_en`=1, a parity bit follows the last data bit. With `cfg_even`=1, the data bits plus the parity bit must hold an even number of ones. With `cfg_even`=0, they must hold an odd number. A mismatch sets `word_perr`. With `cfg_par_en`=0, there is no parity bit and `word_perr` is 0.
- R4: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit must be 1 when `cfg_even`=0 and 0 when `cfg_even`=1. Any other value sets `word_perr`.
- R5: If the first stop bit is sampled as 0, `word_ferr` is set. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: `word_brk` is set when the data bits, the parity bit (if enabled) and the first stop bit are all 0. `word_brk` is never set without `word_ferr`.
- R7: `brk_flag` is set when the line stays low for more than 16 × (1 + data bits + parity bit + stop bits) ticks. In the 8-data, no-parity, one-stop format, a low lasting 156 ticks does not set it and a low lasting 200 ticks does.
- R8: `perr_flag` and `ferr_flag` are set one cycle after a `word_valid` pulse that carries the matching error. `brk_flag` is set by the break event of R7. Each flag stays set until its clear strobe is 1. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R9: `line_stat` is high while any of `perr_flag`, `ferr_flag` and `brk_flag` is 1. It drops only after all three are clear.
- R10: When `cfg_rx_inv`=1, the serial input is inverted before any decoding, so an idle-low line with inverted bits decodes to the same words.
- R11: After reset, `word_valid`, all flags and `line_stat` are 0. `word_valid` is a single-cycle pulse once per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input |
| tick | input | 1 | Oversampling strobe, one cycle wide |
| cfg_wlen | input | 2 | Data-length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Fixed-value parity |
| cfg_two_stop | input | 1 | Two stop bits in the frame time |
| cfg_rx_inv | input | 1 | Invert the serial input |
| clr_perr | input | 1 | Clear strobe for the parity flag |
| clr_ferr | input | 1 | Clear strobe for the framing flag |
| clr_brk | input | 1 | Clear strobe for the break flag |
| word_valid | output | 1 | Received-word pulse |
| word_data | output | 8 | Received data, right-aligned |
| word_perr | output | 1 | Parity error on this word |
| word_ferr | output | 1 | Framing error on this word |
| word_brk | output | 1 | All-zero break character |
| perr_flag | output | 1 | Sticky parity-error flag |
| ferr_flag | output | 1 | Sticky framing-error flag |
| brk_flag | output | 1 | Sticky break flag |
| line_stat | output | 1 | OR of the three sticky flags |

## Verification
A framing error can set the sticky framing flag in the same cycle that software writes the clear strobe for that flag. The bench provokes this directly. It watches for the `word_valid` pulse of a frame whose stop bit is low, and drives `clr_ferr` so that it is active on the very edge where the flag is set. It then requires the flag to read 1, because the set must win. A separate test pulses the clear with no error pending and requires the flag to drop.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  // Right-align a word that was shifted in from the top, LSB first.
  function automatic logic [7:0] align_word(input logic [7:0] sh, input logic [1:0] code);
    return sh >> (3'd3 - {1'b0, code});
  endfunction

  // Parity bit the transmitter should have sent for an aligned word.
  function automatic logic exp_parity(input logic [7:0] d, input logic even, input logic stick);
    if (stick) return ~even;
    return even ? ^d : ~(^d);
  endfunction

  // Ticks in one whole frame: start + data + parity + stop(s).
  function automatic int frame_ticks(input logic [1:0] code, input logic par,
                                     input logic two_stop, input int osr);
    return osr * (7 + int'(code) + int'(par) + int'(two_stop));
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic inv,
  output logic rx_s
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], rx_line ^ inv};
  end

  assign rx_s = q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame import srx_pkg::*; #(
  parameter int OSR = 16,
  localparam int PW = $clog2(OSR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       even,
  input  logic       stick,
  output logic       word_valid,
  output logic [7:0] word_data,
  output logic       word_perr,
  output logic       word_ferr,
  output logic       word_brk
);
  rx_state_e      st;
  logic [PW-1:0]  ph;
  logic [2:0]     bidx;
  logic [7:0]     sh;
  logic           pbit;
  logic           mid_start, bit_end;
  logic [7:0]     data_now;

  assign mid_start = tick && (ph == PW'(OSR/2 - 1));
  assign bit_end   = tick && (ph == PW'(OSR - 1));
  assign data_now  = align_word(sh, wlen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bidx <= '0; sh <= '0; pbit <= 1'b0;
      word_valid <= 1'b0; word_data <= '0;
      word_perr <= 1'b0; word_ferr <= 1'b0; word_brk <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      case (st)
        ST_IDLE: if (!rx_s) begin st <= ST_START; ph <= '0; end
        ST_START: if (tick) begin
          ph <= ph + 1'b1;
          if (mid_start) begin
            ph <= '0;
            if (rx_s) st <= ST_IDLE;
            else begin st <= ST_DATA; bidx <= '0; sh <= '0; pbit <= 1'b0; end
          end
        end
        ST_DATA: if (tick) begin
          ph <= bit_end ? '0 : ph + 1'b1;
          if (bit_end) begin
            sh   <= {rx_s, sh[7:1]};
            bidx <= bidx + 1'b1;
            if (bidx == 3'd4 + {1'b0, wlen}) st <= par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: if (tick) begin
          ph <= bit_end ? '0 : ph + 1'b1;
          if (bit_end) begin pbit <= rx_s; st <= ST_STOP; end
        end
        ST_STOP: if (tick) begin
          ph <= bit_end ? '0 : ph + 1'b1;
          if (bit_end) begin
            word_valid <= 1'b1;
            word_data  <= data_now;
            word_perr  <= par_en && (pbit != exp_parity(data_now, even, stick));
            word_ferr  <= !rx_s;
            word_brk   <= !rx_s && (data_now == 8'd0) && !(par_en && pbit);
            st         <= rx_s ? ST_IDLE : ST_HOLD;
          end
        end
        ST_HOLD: if (rx_s) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_break.sv
module srx_break import srx_pkg::*; #(
  parameter int OSR = 16,
  localparam int MAXT = OSR * 12,
  localparam int CW = $clog2(MAXT + 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       two_stop,
  output logic       brk_event
);
  logic [CW-1:0] lowcnt;
  logic [CW-1:0] limit;

  assign limit     = CW'(frame_ticks(wlen, par_en, two_stop, OSR));
  assign brk_event = tick && !rx_s && (lowcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lowcnt <= '0;
    else if (rx_s)                       lowcnt <= '0;
    else if (tick && (lowcnt <= limit))  lowcnt <= lowcnt + 1'b1;
  end
endmodule

// File: rtl/srx_flags.sv
module srx_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag,
  output logic         any
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end

  assign any = |flag;
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_even,
  input  logic       cfg_stick,
  input  logic       cfg_two_stop,
  input  logic       cfg_rx_inv,
  input  logic       clr_perr,
  input  logic       clr_ferr,
  input  logic       clr_brk,
  output logic       word_valid,
  output logic [7:0] word_data,
  output logic       word_perr,
  output logic       word_ferr,
  output logic       word_brk,
  output logic       perr_flag,
  output logic       ferr_flag,
  output logic       brk_flag,
  output logic       line_stat
);
  logic rx_s;
  logic brk_event;
  logic perr_set, ferr_set;
  logic [2:0] flags;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .inv(cfg_rx_inv), .rx_s(rx_s));

  srx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .even(cfg_even), .stick(cfg_stick),
    .word_valid(word_valid), .word_data(word_data),
    .word_perr(word_perr), .word_ferr(word_ferr), .word_brk(word_brk));

  srx_break #(.OSR(OSR)) u_break (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .two_stop(cfg_two_stop),
    .brk_event(brk_event));

  assign perr_set = word_valid && word_perr;
  assign ferr_set = word_valid && word_ferr;

  srx_flags #(.N(3)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({brk_event, ferr_set, perr_set}),
    .clr({clr_brk, clr_ferr, clr_perr}),
    .flag(flags), .any(line_stat));

  assign perr_flag = flags[0];
  assign ferr_flag = flags[1];
  assign brk_flag  = flags[2];
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst_n,
  input logic word_valid,
  input logic word_perr,
  input logic word_ferr,
  input logic word_brk,
  input logic perr_flag,
  input logic ferr_flag,
  input logic brk_flag,
  input logic line_stat,
  input logic clr_perr,
  input logic clr_ferr,
  input logic clr_brk,
  input logic brk_event
);
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_brk_has_ferr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_brk |-> word_ferr);

  assert_perr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_perr |=> perr_flag);

  assert_ferr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ferr |=> ferr_flag);

  assert_perr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag && !clr_perr |=> perr_flag);

  assert_ferr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ferr && !(word_valid && word_ferr) |=> !ferr_flag);

  assert_brk_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |=> brk_flag);

  assert_brk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !clr_brk && !brk_event |=> brk_flag);

  assert_line_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_stat == (perr_flag || ferr_flag || brk_flag));
endmodule

bind srx_receiver srx_checker u_chk (.*);

// File: tb/sim_srx_receiver.sv
`timescale 1ns/1ps
module sim_srx_receiver;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_line = 1'b1, tick = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 0, cfg_even = 0, cfg_stick = 0, cfg_two_stop = 0, cfg_rx_inv = 0;
  logic clr_perr = 0, clr_ferr = 0, clr_brk = 0;
  logic word_valid, word_perr, word_ferr, word_brk;
  logic [7:0] word_data;
  logic perr_flag, ferr_flag, brk_flag, line_stat;

  int total = 0, bad = 0, got_n = 0;
  logic [7:0] got_d;
  logic got_p, got_f, got_b;
  bit finished = 0;

  srx_receiver u0 (.*);

  initial forever #4 clk = ~clk;

  initial forever begin
    repeat (TDIV - 1) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  initial forever begin
    @(negedge clk);
    if (word_valid) begin
      got_n++; got_d = word_data; got_p = word_perr; got_f = word_ferr; got_b = word_brk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line(input logic v, input int nticks);
    rx_line = v ^ cfg_rx_inv;
    repeat (nticks * TDIV) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input logic use_par,
                            input logic pv, input logic stop_v);
    line(1'b0, 16);
    for (int i = 0; i < n; i++) line(d[i], 16);
    if (use_par) line(pv, 16);
    line(stop_v, 16);
    line(1'b1, 40);
  endtask

  task automatic clr_all;
    @(negedge clk);
    clr_perr = 1; clr_ferr = 1; clr_brk = 1;
    @(negedge clk);
    clr_perr = 0; clr_ferr = 0; clr_brk = 0;
    @(negedge clk);
  endtask

  task automatic expect_word(input string req, input int n0, input logic [7:0] d,
                             input logic p, input logic f, input logic b);
    chk({req, " count"}, got_n, n0 + 1);
    chk({req, " data"}, got_d, d);
    chk({req, " perr"}, got_p, p);
    chk({req, " ferr"}, got_f, f);
    chk({req, " brk"}, got_b, b);
  endtask

  function automatic logic ones_odd(input logic [7:0] d, input int n);
    logic r = 0;
    for (int i = 0; i < n; i++) r ^= d[i];
    return r;
  endfunction

  task automatic t_reset;
    chk("R11 valid after reset", word_valid, 0);
    chk("R11 flags after reset", {perr_flag, ferr_flag, brk_flag}, 0);
    chk("R11 line_stat after reset", line_stat, 0);
  endtask

  task automatic t_lengths;
    cfg_par_en = 0;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] pat = 8'hB5 ^ 8'(c * 17);
      logic [7:0] msk = 8'((1 << (5 + c)) - 1);
      int n0 = got_n;
      cfg_wlen = 2'(c);
      send_frame(pat, 5 + c, 0, 0, 1);
      expect_word("R1 length", n0, pat & msk, 0, 0, 0);
    end
  endtask

  task automatic t_parity;
    int n0;
    cfg_wlen = 3; cfg_par_en = 1; cfg_even = 1; cfg_stick = 0;
    n0 = got_n; send_frame(8'h5A, 8, 1, 0, 1);
    expect_word("R3 even ok", n0, 8'h5A, 0, 0, 0);
    n0 = got_n; send_frame(8'h5A, 8, 1, 1, 1);
    expect_word("R3 even bad", n0, 8'h5A, 1, 0, 0);
    cfg_wlen = 0; cfg_even = 0;
    n0 = got_n; send_frame(8'h13, 5, 1, ~ones_odd(8'h13, 5), 1);
    expect_word("R3 odd ok", n0, 8'h13, 0, 0, 0);
    cfg_par_en = 0; cfg_wlen = 3;
    n0 = got_n; send_frame(8'hC3, 8, 0, 0, 1);
    expect_word("R3 no parity", n0, 8'hC3, 0, 0, 0);
  endtask

  task automatic t_stick;
    int n0;
    cfg_wlen = 2; cfg_par_en = 1; cfg_stick = 1; cfg_even = 0;
    n0 = got_n; send_frame(8'h33, 7, 1, 1, 1);
    expect_word("R4 stick one ok", n0, 8'h33, 0, 0, 0);
    n0 = got_n; send_frame(8'h33, 7, 1, 0, 1);
    expect_word("R4 stick one bad", n0, 8'h33, 1, 0, 0);
    cfg_even = 1;
    n0 = got_n; send_frame(8'h33, 7, 1, 0, 1);
    expect_word("R4 stick zero ok", n0, 8'h33, 0, 0, 0);
    cfg_par_en = 0; cfg_stick = 0; cfg_even = 0; cfg_wlen = 3;
  endtask

  task automatic t_glitch;
    int n0 = got_n;
    line(1'b0, 5);
    line(1'b1, 40);
    chk("R2 short low gives no word", got_n, n0);
    send_frame(8'h81, 8, 0, 0, 1);
    expect_word("R2 frame after glitch", n0, 8'h81, 0, 0, 0);
  endtask

  task automatic t_framing;
    int n0;
    clr_all;
    n0 = got_n; send_frame(8'h3C, 8, 0, 0, 0);
    expect_word("R5 bad stop", n0, 8'h3C, 0, 1, 0);
    chk("R8 ferr flag set", ferr_flag, 1);
    chk("R9 line_stat from ferr", line_stat, 1);
    clr_all;
    chk("R8 ferr flag cleared", ferr_flag, 0);
    chk("R9 line_stat clear", line_stat, 0);
  endtask

  task automatic t_break;
    int n0;
    clr_all;
    n0 = got_n;
    line(1'b0, 156);
    line(1'b1, 40);
    expect_word("R6 short break char", n0, 8'h00, 0, 1, 1);
    chk("R7 156 ticks low no break", brk_flag, 0);
    clr_all;
    n0 = got_n;
    line(1'b0, 200);
    line(1'b1, 40);
    expect_word("R6 long break char", n0, 8'h00, 0, 1, 1);
    chk("R7 200 ticks low break", brk_flag, 1);
    @(negedge clk); clr_ferr = 1; @(negedge clk); clr_ferr = 0; @(negedge clk);
    chk("R9 line_stat held by brk", line_stat, 1);
    @(negedge clk); clr_brk = 1; @(negedge clk); clr_brk = 0; @(negedge clk);
    chk("R9 line_stat drops", line_stat, 0);
  endtask

  task automatic t_same_cycle;
    clr_all;
    fork
      send_frame(8'h5F, 8, 0, 0, 0);
      begin
        @(negedge clk);
        while (!word_valid) @(negedge clk);
        clr_ferr = 1;
        @(negedge clk);
        clr_ferr = 0;
        chk("R8 set wins over clear", ferr_flag, 1);
      end
    join
    clr_all;
  endtask

  task automatic t_invert;
    int n0 = got_n;
    @(negedge clk);
    cfg_rx_inv = 1; rx_line = 1'b0;
    line(1'b1, 40);
    send_frame(8'hA7, 8, 0, 0, 1);
    expect_word("R10 inverted input", n0, 8'hA7, 0, 0, 0);
    @(negedge clk);
    cfg_rx_inv = 0; rx_line = 1'b1;
    line(1'b1, 40);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_lengths;
    t_parity;
    t_stick;
    t_glitch;
    t_framing;
    t_break;
    t_same_cycle;
    t_invert;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule